// File: doc/BRIEF.md
# Multi-Source Reset Pulse Stretcher

This block spreads reset requests from four watchdog timers over four module slots. Each watchdog drives two request lines into the block. A global line asks for every slot to be reset. A local line asks for the reset of its own slot only. The block watches all eight lines for rising edges. It turns each request into an active-low reset for the affected slots, and holds that reset for a fixed number of clock cycles.

Each slot keeps its own hold timer, so the slots can be at different points of their reset windows at the same time. A new request that reaches a slot already in reset restarts that slot's window at full length. All logic runs in one clock domain. Synchronising the resets into other domains is left to the logic that receives them.

Top module: `reset_pulse_stretcher`

## Requirements
- R1: While `rst_n_i` is low, and from the first clock edge after it rises until a trigger, every bit of `slot_rst_n_o` is 1 (released).
- R2: A rising edge on any bit of `wd_global_i` drives all four bits of `slot_rst_n_o` to 0 from the clock edge that samples the edge.
- R3: A rising edge on bit N of `wd_local_i` drives only bit N of `slot_rst_n_o` to 0. The other slots keep their state.
- R4: A triggered slot output stays 0 for exactly 2^HOLD_LOG2 clock cycles (2^20 by default), then returns to 1.
- R5: A trigger that reaches a slot already held in reset restarts its window, so the slot stays 0 for 2^HOLD_LOG2 cycles counted from the new trigger.
- R6: Only a 0-to-1 transition of an input (sampled on consecutive clock edges) is a trigger. An input held at 1 for longer produces a single window.
- R7: Global and local triggers that reach a slot in the same cycle give one window of normal length, the same as a single trigger.
- R8: Each slot times its window on its own, so triggers at different times give windows that end at different times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Synchronous active-low block reset |
| wd_global_i | input | 4 | Global reset requests, one per watchdog |
| wd_local_i | input | 4 | Local reset requests, bit N for slot N |
| slot_rst_n_o | output | 4 | Active-low slot resets, bit N for slot N |

## Verification
Two things can happen in the same cycle. A global and a local request can arrive together. A new request can also arrive in the very cycle a slot's window would end, or partway through it. The bench sweeps every pair of global and local request patterns as single-cycle pulses, which covers both kinds of request arriving together. It also fires second requests at a slot that is partway through its window. An arithmetic model of remaining hold cycles for each slot judges the output of every slot on every cycle. A shortened hold length keeps the full windows inside the run.

// File: rtl/rst_stretch_pkg.sv
// Package: shared defaults and the slot state type for the reset stretcher.
// Assumes a single clock domain for every user of these definitions.
package rst_stretch_pkg;
    localparam int unsigned DEF_SLOTS     = 4;
    localparam int unsigned DEF_HOLD_LOG2 = 20;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;
endpackage

// File: rtl/pulse_rise_detect.sv
// Module: pulse_rise_detect
// Flags a 0-to-1 transition of each input bit between two consecutive clock
// edges. Assumes inputs are already synchronous to clk_i. After block reset
// the previous value is taken as 0.
module pulse_rise_detect #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    // Keep last cycle's level of every request line.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            prev_q <= '0;
        end else begin
            prev_q <= level_i;
        end
    end

    // A rise is the line high now and low on the previous edge.
    always_comb begin
        rise_o = level_i & ~prev_q;
    end

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_chk
            // R6
            single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                rise_o[b] |=> !rise_o[b]);
        end
    endgenerate
endmodule

// File: rtl/trigger_merge.sv
// Module: trigger_merge
// Combines global rises (any one hits every slot) with local rises (one slot
// each) into one trigger per slot. Coincident sources give a single trigger.
module trigger_merge #(
    parameter int unsigned SLOTS = 4
) (
    input  logic [SLOTS-1:0] glob_rise_i,
    input  logic [SLOTS-1:0] loc_rise_i,
    output logic [SLOTS-1:0] slot_trig_o
);
    logic any_glob;

    // Reduce the global sources and fan the result out to every slot.
    always_comb begin
        any_glob    = |glob_rise_i;
        slot_trig_o = {SLOTS{any_glob}} | loc_rise_i;
    end
endmodule

// File: rtl/slot_hold_timer.sv
// Module: slot_hold_timer
// Holds one slot in reset for 2^HOLD_LOG2 cycles after a trigger. A trigger
// during the hold reloads the full count. held_o comes straight from a flop.
module slot_hold_timer
    import rst_stretch_pkg::*;
#(
    parameter int unsigned HOLD_LOG2 = DEF_HOLD_LOG2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic trig_i,
    output logic held_o
);
    localparam logic [HOLD_LOG2-1:0] CNT_FULL = '1;
    localparam logic [HOLD_LOG2-1:0] CNT_ONE  = HOLD_LOG2'(1);

    slot_state_e             state_q;
    logic [HOLD_LOG2-1:0]    left_q;

    // Load on trigger, count down while held, release after the last cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= SLOT_IDLE;
            left_q  <= '0;
        end else if (trig_i) begin
            state_q <= SLOT_HELD;
            left_q  <= CNT_FULL;
        end else if (state_q == SLOT_HELD) begin
            if (left_q == '0) begin
                state_q <= SLOT_IDLE;
            end else begin
                left_q <= left_q - CNT_ONE;
            end
        end
    end

    // Expose the held state.
    always_comb begin
        held_o = (state_q == SLOT_HELD);
    end

    // R5
    reload_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        trig_i |=> (held_o && left_q == CNT_FULL));
    // R4
    countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (held_o && !trig_i && left_q != '0) |=> (held_o && left_q == $past(left_q) - CNT_ONE));
    // R4
    release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (held_o && !trig_i && left_q == '0) |=> !held_o);
    // R1
    idle_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!held_o && !trig_i) |=> !held_o);
endmodule

// File: rtl/reset_pulse_stretcher.sv
// Module: reset_pulse_stretcher (top)
// Detects rising edges on global and local watchdog requests, merges them per
// slot and stretches each into an active-low slot reset of 2^HOLD_LOG2 cycles.
// Assumes all requests are synchronous to clk_i. Each output is the inverse
// of a single flop, so it cannot glitch.
module reset_pulse_stretcher
    import rst_stretch_pkg::*;
#(
    parameter int unsigned SLOTS     = DEF_SLOTS,
    parameter int unsigned HOLD_LOG2 = DEF_HOLD_LOG2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [SLOTS-1:0] wd_global_i,
    input  logic [SLOTS-1:0] wd_local_i,
    output logic [SLOTS-1:0] slot_rst_n_o
);
    logic [SLOTS-1:0] glob_rise;
    logic [SLOTS-1:0] loc_rise;
    logic [SLOTS-1:0] slot_trig;
    logic [SLOTS-1:0] slot_held;

    pulse_rise_detect #(.WIDTH(SLOTS)) glob_det_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .level_i (wd_global_i),
        .rise_o  (glob_rise)
    );

    pulse_rise_detect #(.WIDTH(SLOTS)) loc_det_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .level_i (wd_local_i),
        .rise_o  (loc_rise)
    );

    trigger_merge #(.SLOTS(SLOTS)) merge_i (
        .glob_rise_i (glob_rise),
        .loc_rise_i  (loc_rise),
        .slot_trig_o (slot_trig)
    );

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            slot_hold_timer #(.HOLD_LOG2(HOLD_LOG2)) timer_i (
                .clk_i   (clk_i),
                .rst_n_i (rst_n_i),
                .trig_i  (slot_trig[s]),
                .held_o  (slot_held[s])
            );

            // R3
            local_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                loc_rise[s] |=> !slot_rst_n_o[s]);
        end
    endgenerate

    // Drive the active-low outputs from the hold flops.
    always_comb begin
        slot_rst_n_o = ~slot_held;
    end

    // R2
    global_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (|glob_rise) |=> (slot_rst_n_o == '0));
    // R1
    reset_release_chk: assert property (@(posedge clk_i)
        !rst_n_i |=> (slot_rst_n_o == '1));
endmodule

// File: tb/reset_pulse_stretcher_tb_top.sv
`timescale 1ns/1ps
module reset_pulse_stretcher_tb_top;
    localparam int unsigned SLOTS     = 4;
    localparam int unsigned HOLD_LOG2 = 4;
    localparam int          HOLD      = 1 << HOLD_LOG2;
    localparam int          WD_LIMIT  = 40000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [SLOTS-1:0] glob;
    logic [SLOTS-1:0] loc;
    logic [SLOTS-1:0] rst_n_out;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    int               exp_left [SLOTS];
    logic [SLOTS-1:0] prev_g;
    logic [SLOTS-1:0] prev_l;

    reset_pulse_stretcher #(.SLOTS(SLOTS), .HOLD_LOG2(HOLD_LOG2)) dut_i (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .wd_global_i  (glob),
        .wd_local_i   (loc),
        .slot_rst_n_o (rst_n_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cycles++;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    endtask

    // Compare every slot against the model.
    task automatic check_all(string tag);
        for (int s = 0; s < SLOTS; s++) begin
            logic exp_bit;
            exp_bit = (exp_left[s] > 0) ? 1'b0 : 1'b1;
            checks++;
            if (rst_n_out[s] !== exp_bit) begin
                failures++;
                $display("FAIL %s slot %0d: got %b expected %b (cycle %0d)",
                         tag, s, rst_n_out[s], exp_bit, cycles);
            end
        end
    endtask

    // Drive one cycle of requests, advance the model by one edge, then check.
    task automatic step(logic [SLOTS-1:0] g, logic [SLOTS-1:0] l, string tag);
        logic [SLOTS-1:0] g_rise;
        logic [SLOTS-1:0] l_rise;
        glob   = g;
        loc    = l;
        g_rise = g & ~prev_g;
        l_rise = l & ~prev_l;
        prev_g = g;
        prev_l = l;
        for (int s = 0; s < SLOTS; s++) begin
            if ((|g_rise) || l_rise[s]) exp_left[s] = HOLD;
            else if (exp_left[s] > 0) exp_left[s] = exp_left[s] - 1;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step('0, '0, tag);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        glob  = '0;
        loc   = '0;
        prev_g = '0;
        prev_l = '0;
        for (int s = 0; s < SLOTS; s++) exp_left[s] = 0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        while (cycles < WD_LIMIT) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WD_LIMIT);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        glob  = '0;
        loc   = '0;
        @(negedge clk);
        apply_reset();
        // R1: stay released with no requests
        idle(4, "R1");

        // R2 R3 R7 R4: every pair of global and local patterns as one pulse
        for (int g = 0; g < (1 << SLOTS); g++) begin
            for (int l = 0; l < (1 << SLOTS); l++) begin
                string tag;
                if (g != 0 && l != 0) tag = "R7";
                else if (g != 0)      tag = "R2";
                else                  tag = "R3";
                step(SLOTS'(g), SLOTS'(l), tag);
                idle(HOLD + 1, "R4");
            end
        end

        // R5: retrigger a held slot partway and on its last held cycle
        step('0, 4'b1000, "R5");
        idle(HOLD - 4, "R5");
        step('0, 4'b1000, "R5");
        idle(HOLD - 1, "R5");
        step(4'b0001, '0, "R5");
        idle(HOLD + 2, "R5");

        // R6: a request held high gives one window only
        step(4'b0100, '0, "R6");
        for (int i = 0; i < 3 * HOLD; i++) step(4'b0100, '0, "R6");
        step('0, 4'b0010, "R6");
        for (int i = 0; i < 2 * HOLD; i++) step('0, 4'b0010, "R6");
        idle(2, "R6");

        // R8: staggered local triggers, windows end at different times
        step('0, 4'b0001, "R8");
        idle(3, "R8");
        step('0, 4'b0100, "R8");
        idle(5, "R8");
        step('0, 4'b0010, "R8");
        idle(2, "R8");
        step('0, 4'b1000, "R8");
        idle(2 * HOLD, "R8");

        // R1: reset in the middle of a window releases every slot
        step(4'b0010, '0, "R1");
        idle(5, "R1");
        apply_reset();
        idle(4, "R1");

        finish_run();
    end
endmodule